// File: doc/BRIEF.md
# Transmit Idle Line Pattern Generator

This block supplies the transmit line whenever the serializer has no character, frame or message to send. While the transmitter requests idle, the block sends a repeating pattern unit, one bit per bit-clock enable. A 3-bit selector chooses the unit. It can be the protocol's own filler, an alternating or constant data pattern that still passes through the line coder, or an alternating or constant level that goes straight onto the line.

Each unit is captured from the selector, the mode and the sync character only when the previous unit has run out. A change to any of these inputs in the middle of a unit therefore never produces a broken unit. A one-cycle idle-sent pulse reports that the first full unit has gone out after the block entered idle.

The controller has three states. In ST_OFF the block is not idle. In ST_FIRST the first unit is going out. In ST_REPEAT later units are going out. The transitions are:
- ENTER: ST_OFF to ST_FIRST, when the idle request is high.
- FIRST_DONE: ST_FIRST to ST_REPEAT, at the last bit of the first unit. This transition raises the pulse.
- WRAP: ST_REPEAT to itself, at each unit boundary.
- LEAVE: any running state to ST_OFF, whenever the request is low.

Top module: `idle_line_gen`

## Requirements
- R1: After reset, and whenever the block is inactive, the outputs are `idle_valid`=0, `tx_bit`=1, `line_direct`=0 and `idle_sent`=0. A clock edge that samples `idle_req` low makes the block inactive from the next cycle on.
- R2: The edge that samples `idle_req` high while the block is inactive loads the first unit, and its bit 0 appears on `tx_bit` after that edge. Each later edge with `bit_en` high moves to the next unit bit, LSB first. With `bit_en` low, `tx_bit` and `line_direct` hold.
- R3: Selector 000, and the reserved code 100, send the mode default with `line_direct`=0. The mode encoding is 00 = async, 01 = character sync, 10 = bit-oriented and 11 = async. In character-sync mode the default is the 8-bit `sync_char` sent LSB first. In bit-oriented mode it is the flag 01111110 (8'h7E) sent LSB first, back to back, with no extra zeros inserted. In async mode it is a steady 1 as a 1-bit unit.
- R4: Selector 001 sends a 2-bit unit, 0 then 1, with `line_direct`=0.
- R5: Selector 010 sends a steady 0 and selector 011 a steady 1. Each is a 1-bit unit with `line_direct`=0.
- R6: Selectors 101, 110 and 111 set `line_direct`=1. 101 sends a 2-bit unit of mark (1) then space (0), 110 a steady 0, and 111 a steady 1.
- R7: A change to `idle_sel`, `tx_mode` or `sync_char` in the middle of a unit does not affect the remaining bits of that unit. It takes effect from the next unit boundary.
- R8: `idle_sent` is a one-cycle pulse. It appears in the cycle after the edge that completes the first unit following entry to idle, and only once for each entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_req | input | 1 | Transmitter has nothing to send; run the idle pattern |
| bit_en | input | 1 | One bit time has elapsed; advance one bit |
| tx_mode | input | 2 | Protocol mode: 00 async, 01 char sync, 10 bit-oriented, 11 async |
| sync_char | input | 8 | Sync character of character-sync mode |
| idle_sel | input | 3 | Idle pattern selector |
| tx_bit | output | 1 | Current idle bit or line level |
| line_direct | output | 1 | 1 = bit bypasses line coding and is the line level |
| idle_valid | output | 1 | Block is driving the idle pattern |
| idle_sent | output | 1 | Pulse after the first complete idle unit |

## Verification
The assertions check on every cycle that `idle_sent` is a single pulse and only occurs while idle. They also check that it never coincides with entry to idle, that a low request ends idle on the next cycle, and that the bit and level hold while `bit_en` is low. Inside the shifter they check that a shift never passes the unit end and never collides with a reload. Only the bench scenarios can show the actual bit sequences of each selector and mode, and the placement of the idle-sent pulse at the unit length. They also show that a mid-unit selector or sync character change is deferred to the boundary.

// File: rtl/idle_gen_pkg.sv
package idle_gen_pkg;

    localparam int unsigned UNIT_W = 8;
    localparam int unsigned IDX_W  = $clog2(UNIT_W);

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_CHAR  = 2'b01,
        MODE_BITO  = 2'b10,
        MODE_SPARE = 2'b11
    } tx_mode_e;

    typedef enum logic [2:0] {
        SEL_DEFAULT = 3'b000,
        SEL_ALT01   = 3'b001,
        SEL_ZEROS   = 3'b010,
        SEL_ONES    = 3'b011,
        SEL_RSVD    = 3'b100,
        SEL_ALT_MS  = 3'b101,
        SEL_SPACE   = 3'b110,
        SEL_MARK    = 3'b111
    } idle_sel_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_FIRST  = 2'b01,
        ST_REPEAT = 2'b10
    } idle_state_e;

    // One pattern unit: bits sent LSB first, index of the last bit, bypass flag
    typedef struct packed {
        logic [UNIT_W-1:0] bits;
        logic [IDX_W-1:0]  last_idx;
        logic              direct;
    } unit_t;

endpackage

// File: rtl/idle_unit_sel.sv
module idle_unit_sel
    import idle_gen_pkg::*;
#(
    parameter logic [UNIT_W-1:0] FLAG_PAT = 8'h7E
) (
    input  logic [1:0]        tx_mode,
    input  logic [UNIT_W-1:0] sync_char,
    input  logic [2:0]        idle_sel,
    output unit_t             unit_o
);

    localparam logic [IDX_W-1:0]  IDX_SINGLE = IDX_W'(0);
    localparam logic [IDX_W-1:0]  IDX_PAIR   = IDX_W'(1);
    localparam logic [IDX_W-1:0]  IDX_FULL   = IDX_W'(UNIT_W - 1);
    localparam logic [UNIT_W-1:0] PAT_LOHI   = {(UNIT_W/2){2'b10}};
    localparam logic [UNIT_W-1:0] PAT_HILO   = {(UNIT_W/2){2'b01}};

    unit_t dflt;

    // Protocol filler used between messages
    always_comb begin
        dflt.bits     = '1;
        dflt.last_idx = IDX_SINGLE;
        dflt.direct   = 1'b0;
        unique case (tx_mode_e'(tx_mode))
            MODE_CHAR: begin
                dflt.bits     = sync_char;
                dflt.last_idx = IDX_FULL;
            end
            MODE_BITO: begin
                dflt.bits     = FLAG_PAT;
                dflt.last_idx = IDX_FULL;
            end
            MODE_ASYNC, MODE_SPARE: begin
                dflt.bits     = '1;
                dflt.last_idx = IDX_SINGLE;
            end
        endcase
    end

    always_comb begin
        unit_o = dflt;
        unique case (idle_sel_e'(idle_sel))
            SEL_DEFAULT, SEL_RSVD: unit_o = dflt;
            SEL_ALT01: begin
                unit_o.bits     = PAT_LOHI;
                unit_o.last_idx = IDX_PAIR;
                unit_o.direct   = 1'b0;
            end
            SEL_ZEROS: begin
                unit_o.bits     = '0;
                unit_o.last_idx = IDX_SINGLE;
                unit_o.direct   = 1'b0;
            end
            SEL_ONES: begin
                unit_o.bits     = '1;
                unit_o.last_idx = IDX_SINGLE;
                unit_o.direct   = 1'b0;
            end
            SEL_ALT_MS: begin
                unit_o.bits     = PAT_HILO;
                unit_o.last_idx = IDX_PAIR;
                unit_o.direct   = 1'b1;
            end
            SEL_SPACE: begin
                unit_o.bits     = '0;
                unit_o.last_idx = IDX_SINGLE;
                unit_o.direct   = 1'b1;
            end
            SEL_MARK: begin
                unit_o.bits     = '1;
                unit_o.last_idx = IDX_SINGLE;
                unit_o.direct   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/idle_unit_shift.sv
module idle_unit_shift
    import idle_gen_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  advance,
    input  unit_t unit_in,
    output logic  bit_out,
    output logic  direct_out,
    output logic  at_last
);

    logic [UNIT_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;
    logic              dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '1;
            idx_q <= '0;
            dir_q <= 1'b0;
        end else if (load) begin
            sh_q  <= unit_in.bits;
            idx_q <= unit_in.last_idx;
            dir_q <= unit_in.direct;
        end else if (advance) begin
            sh_q  <= {1'b1, sh_q[UNIT_W-1:1]};
            idx_q <= idx_q - 1'b1;
        end
    end

    assign bit_out    = sh_q[0];
    assign direct_out = dir_q;
    assign at_last    = (idx_q == '0);

    // R2: a shift never runs past the end of the unit
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (idx_q != '0));

    // R2: reload and shift are never requested together
    p_load_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && advance));

endmodule

// File: rtl/idle_line_gen.sv
module idle_line_gen
    import idle_gen_pkg::*;
#(
    parameter logic [UNIT_W-1:0] FLAG_PAT = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_req,
    input  logic              bit_en,
    input  logic [1:0]        tx_mode,
    input  logic [UNIT_W-1:0] sync_char,
    input  logic [2:0]        idle_sel,
    output logic              tx_bit,
    output logic              line_direct,
    output logic              idle_valid,
    output logic              idle_sent
);

    idle_state_e state_q, state_d;
    logic        sent_q, sent_d;
    logic        load, advance;
    unit_t       next_unit;
    logic        sh_bit, sh_direct, sh_last;

    idle_unit_sel #(.FLAG_PAT(FLAG_PAT)) u_sel (
        .tx_mode   (tx_mode),
        .sync_char (sync_char),
        .idle_sel  (idle_sel),
        .unit_o    (next_unit)
    );

    idle_unit_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .advance    (advance),
        .unit_in    (next_unit),
        .bit_out    (sh_bit),
        .direct_out (sh_direct),
        .at_last    (sh_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            sent_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sent_q  <= sent_d;
        end
    end

    // Transitions: ENTER, FIRST_DONE, WRAP, LEAVE
    always_comb begin
        state_d = state_q;
        sent_d  = 1'b0;
        load    = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (idle_req) begin
                    load    = 1'b1;
                    state_d = ST_FIRST;
                end
            end
            ST_FIRST, ST_REPEAT: begin
                if (!idle_req) begin
                    state_d = ST_OFF;
                end else if (bit_en) begin
                    if (sh_last) begin
                        load = 1'b1;
                        if (state_q == ST_FIRST) begin
                            sent_d  = 1'b1;
                            state_d = ST_REPEAT;
                        end
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        idle_valid  = (state_q != ST_OFF);
        tx_bit      = idle_valid ? sh_bit : 1'b1;
        line_direct = idle_valid ? sh_direct : 1'b0;
        idle_sent   = sent_q;
    end

    p_sent_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_sent |=> !idle_sent);

    p_sent_in_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_sent |-> idle_valid);

    p_no_sent_on_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_valid) |-> !idle_sent);

    p_leave_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req |=> (!idle_valid && tx_bit && !line_direct));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_valid && idle_req && !bit_en) |=> ($stable(tx_bit) && $stable(line_direct)));

endmodule

// File: tb/idle_line_gen_tb_top.sv
`timescale 1ns/1ps
module idle_line_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_req = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] tx_mode = 2'b00;
    logic [7:0] sync_char = 8'h00;
    logic [2:0] idle_sel = 3'b000;
    logic       tx_bit, line_direct, idle_valid, idle_sent;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    idle_line_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_req    (idle_req),
        .bit_en      (bit_en),
        .tx_mode     (tx_mode),
        .sync_char   (sync_char),
        .idle_sel    (idle_sel),
        .tx_bit      (tx_bit),
        .line_direct (line_direct),
        .idle_valid  (idle_valid),
        .idle_sent   (idle_sent)
    );

    // {mode[2], sel[3], sync_char[8], stream[16] (bit i = sample i), len[4], direct[1]}
    localparam int NVEC = 12;
    localparam logic [33:0] VECS [NVEC] = '{
        {2'b00, 3'b000, 8'h00, 16'hFFFF, 4'd1, 1'b0},
        {2'b01, 3'b000, 8'h16, 16'h1616, 4'd8, 1'b0},
        {2'b10, 3'b000, 8'h00, 16'h7E7E, 4'd8, 1'b0},
        {2'b01, 3'b001, 8'h16, 16'hAAAA, 4'd2, 1'b0},
        {2'b00, 3'b010, 8'h00, 16'h0000, 4'd1, 1'b0},
        {2'b10, 3'b011, 8'h00, 16'hFFFF, 4'd1, 1'b0},
        {2'b01, 3'b100, 8'hA5, 16'hA5A5, 4'd8, 1'b0},
        {2'b10, 3'b101, 8'h00, 16'h5555, 4'd2, 1'b1},
        {2'b00, 3'b110, 8'h00, 16'h0000, 4'd1, 1'b1},
        {2'b01, 3'b111, 8'h3C, 16'hFFFF, 4'd1, 1'b1},
        {2'b11, 3'b000, 8'h00, 16'hFFFF, 4'd1, 1'b0},
        {2'b10, 3'b100, 8'h00, 16'h7E7E, 4'd8, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string sel_tag(input logic [2:0] s);
        case (s)
            3'b000, 3'b100: return "R3";
            3'b001:         return "R4";
            3'b010, 3'b011: return "R5";
            default:        return "R6";
        endcase
    endfunction

    task automatic leave_idle();
        @(negedge clk);
        idle_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!idle_valid && tx_bit && !line_direct && !idle_sent, "R1 leave idle",
            int'({idle_valid, tx_bit, line_direct, idle_sent}), 4'b0100);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!idle_valid && tx_bit && !line_direct && !idle_sent, "R1 reset",
            int'({idle_valid, tx_bit, line_direct, idle_sent}), 4'b0100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!idle_valid && tx_bit, "R1 inactive", int'({idle_valid, tx_bit}), 2'b01);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  m;
            logic [2:0]  s;
            logic [7:0]  sc;
            logic [15:0] st;
            logic [3:0]  ln;
            logic        dr;
            string       tag;
            {m, s, sc, st, ln, dr} = VECS[v];
            tag = sel_tag(s);
            @(negedge clk);
            tx_mode = m; idle_sel = s; sync_char = sc;
            idle_req = 1'b1; bit_en = 1'b1;
            @(posedge clk);
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                chk(tx_bit == st[i], $sformatf("%s vec %0d bit %0d", tag, v, i),
                    int'(tx_bit), int'(st[i]));
                chk(line_direct == dr, $sformatf("%s vec %0d direct", tag, v),
                    int'(line_direct), int'(dr));
                // R8: pulse exactly after the first unit
                chk(idle_sent == (i == int'(ln)), $sformatf("R8 vec %0d sample %0d", v, i),
                    int'(idle_sent), int'(i == int'(ln)));
            end
            leave_idle();
        end

        // R2: bit_en low holds the first bit, no advance, no pulse
        @(negedge clk);
        tx_mode = 2'b01; idle_sel = 3'b000; sync_char = 8'h16;
        idle_req = 1'b1; bit_en = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(tx_bit == 1'b0 && idle_valid && !idle_sent, "R2 hold without bit_en",
                int'({tx_bit, idle_valid, idle_sent}), 3'b010);
        end
        bit_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(tx_bit == 1'b1, "R2 advance to bit 1", int'(tx_bit), 1);
        leave_idle();

        // R7: selector and sync char change mid-unit deferred to boundary
        @(negedge clk);
        tx_mode = 2'b01; idle_sel = 3'b000; sync_char = 8'h16;
        idle_req = 1'b1; bit_en = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 12; i++) begin
            logic e;
            @(negedge clk);
            e = (i < 8) ? 1'(8'h16 >> i) : 1'b1;
            chk(tx_bit == e, $sformatf("R7 sample %0d", i), int'(tx_bit), int'(e));
            if (i == 8)
                chk(idle_sent, "R8 pulse after changed unit", int'(idle_sent), 1);
            if (i == 2) begin
                idle_sel = 3'b011;
                sync_char = 8'hFF;
            end
        end
        chk(!line_direct, "R7 coded after change", int'(line_direct), 0);
        leave_idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule